// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs the write and status-poll sequences that a 32-bit parallel NOR bank needs. The bank is built from two 16-bit devices that share one bus word. A host asks for one operation at a time: erase a block, program one word, or clear a block's lock. It does so with a start strobe, an operation code, a word address and a data word. The sequencer issues the command writes for that operation, one bus transaction at a time, over a valid/ready port. Each command byte is copied into all four byte lanes.

It then reads the status word until both devices report ready, and decodes the error flags of each device. It enforces a timeout counted in clock cycles and puts the bank back into read-array mode. It finishes with a one-cycle done strobe that carries a result code: 0 for success, 1 for a device error or timeout, and 2 for a word that is not erased enough to program.

Erase waits a fixed settle time before its first status read. The erase and program timeout limits are sampled from their inputs at start.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o and bus_valid_o are all low.
- R2: A start_i with op_i 0 (erase), 1 (program) or 2 (unlock) is accepted only while busy_o is low. busy_o is high from the next cycle through the done cycle, and low in the cycle after done. A start with op_i 3, or any start while busy, has no effect.
- R3: A bus request keeps bus_valid_o, bus_we_o, bus_addr_o and bus_wdata_o steady until bus_ready_i. Only one request is outstanding. Every bus access of an operation uses the address given at start.
- R4: Command words carry the command byte in all four byte lanes. Erase writes FF, 50, 20, D0 and then D0 a second time.
- R5: After the last erase confirm has been accepted, at least SETTLE_CYC cycles pass before the first status read.
- R6: Ready means status bits 7 and 23 are both set. A status word with only one of them set is polled again.
- R7: During an erase, a not-ready status with bit 5 or bit 21 set ends the operation: the block writes FF and reports result 1.
- R8: Program first reads the target word. If (read AND data) differs from data, the result is 2 and no write is issued.
- R9: Program writes 10101010, then the data word, then polls. At ready it writes 50505050 and then FFFFFFFF. The result is 1 if the ready status has any bit of 0x40404040 set, and 0 otherwise.
- R10: Unlock writes FF, 50, 60, D0 and polls. At ready it reports result 0 with no further write.
- R11: Polling cycles are counted from entry into the poll phase. A not-ready status that returns after the count has exceeded the limit ends the operation with result 1. Program uses prog_tmo_i and then writes 50 and FF; erase and unlock use erase_tmo_i and then write FF.
- R12: done_o lasts one cycle, result_o is valid with it, and result_o is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 2 | 0 erase, 1 program, 2 unlock, 3 reserved |
| addr_i | input | AW | Word address of the block or word |
| data_i | input | 32 | Word to program |
| erase_tmo_i | input | TW | Poll limit in cycles for erase and unlock |
| prog_tmo_i | input | TW | Poll limit in cycles for program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2 | 0 ok, 1 error or timeout, 2 not erased |
| bus_valid_o | output | 1 | Bus request valid |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Bus word address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ready_i | input | 1 | Bus accepts the request, read data valid |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
The handshake properties assume that bus_ready_i is asserted only while bus_valid_o is high and that bus_rdata_i is valid in that same cycle. The bench's bus responder asserts ready only in reply to a pending request, after a rotating wait of zero to two cycles.

The start properties assume that op_i and start_i are steady across a clock edge. The bench changes them only on falling edges.

Status words come from a per-test queue and then from a fixed idle value. This keeps each poll outcome deliberate: half-ready words, lock errors, write errors, and a status that is never ready, which drives the timeouts.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    OP_ERASE  = 2'd0,
    OP_PROG   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_FAIL  = 2'd1,
    RES_DIRTY = 2'd2
  } res_e;

  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_CLRST = 8'h50;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_PROG  = 8'h10;
  localparam logic [7:0] CMD_UNLK  = 8'h60;

  localparam logic [31:0] ST_READY  = 32'h0080_0080;
  localparam logic [31:0] ST_LOCKER = 32'h0020_0020;
  localparam logic [31:0] ST_WRERR  = 32'h4040_4040;

  function automatic logic [31:0] lanes(input logic [7:0] b);
    return {4{b}};
  endfunction
endpackage

// File: rtl/nor_cyc_cnt.sv
module nor_cyc_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (en_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nor_bus_port.sv
module nor_bus_port #(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          resp_o,
  output logic [31:0]   rdata_o,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [31:0]   bus_rdata_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_o <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      resp_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      resp_o <= 1'b0;
      if (bus_valid_o && bus_ready_i) begin
        bus_valid_o <= 1'b0;
        resp_o      <= 1'b1;
        rdata_o     <= bus_rdata_i;
      end else if (req_i && !bus_valid_o) begin
        bus_valid_o <= 1'b1;
        bus_we_o    <= req_we_i;
        bus_addr_o  <= req_addr_i;
        bus_wdata_o <= req_wdata_i;
      end
    end
  end
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int AW         = 24,
  parameter int TW         = 24,
  parameter int SETTLE_CYC = 50000,
  parameter int SW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   data_i,
  input  logic [TW-1:0] erase_tmo_i,
  input  logic [TW-1:0] prog_tmo_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          req_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [31:0]   req_wdata_o,
  input  logic          resp_i,
  input  logic [31:0]   rdata_i,
  output logic          tmo_clr_o,
  output logic          tmo_en_o,
  input  logic [TW-1:0] tmo_cnt_i,
  output logic          set_clr_o,
  output logic          set_en_o,
  input  logic [SW-1:0] set_cnt_i
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_CMD, S_SETTLE, S_POLL, S_TAIL, S_DONE
  } state_e;

  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYC - 1);

  state_e        state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic [TW-1:0] elim_q, plim_q;
  logic [2:0]    idx_q;
  logic          pend_q;
  logic [1:0]    res_q;

  function automatic logic [2:0] head_last(input op_e op);
    case (op)
      OP_ERASE: return 3'd4;
      OP_PROG:  return 3'd1;
      default:  return 3'd3;
    endcase
  endfunction

  function automatic logic [31:0] head_word(input op_e op, input logic [2:0] i,
                                            input logic [31:0] d);
    case (op)
      OP_ERASE:
        case (i)
          3'd0:    return lanes(CMD_ARRAY);
          3'd1:    return lanes(CMD_CLRST);
          3'd2:    return lanes(CMD_ERASE);
          default: return lanes(CMD_CONF);  // confirm, then resume
        endcase
      OP_PROG:
        return (i == 3'd0) ? lanes(CMD_PROG) : d;
      default:
        case (i)
          3'd0:    return lanes(CMD_ARRAY);
          3'd1:    return lanes(CMD_CLRST);
          3'd2:    return lanes(CMD_UNLK);
          default: return lanes(CMD_CONF);
        endcase
    endcase
  endfunction

  logic [TW-1:0] tmo_lim;
  logic          st_ready, st_lock, st_wrerr, tmo_over, last_head, last_tail;
  logic          in_bus_state;

  assign tmo_lim   = (op_q == OP_PROG) ? plim_q : elim_q;
  assign tmo_over  = tmo_cnt_i > tmo_lim;
  assign st_ready  = (rdata_i & ST_READY) == ST_READY;
  assign st_lock   = |(rdata_i & ST_LOCKER);
  assign st_wrerr  = |(rdata_i & ST_WRERR);
  assign last_head = idx_q == head_last(op_q);
  assign last_tail = (op_q != OP_PROG) || (idx_q == 3'd1);

  assign in_bus_state = (state_q == S_CHECK) || (state_q == S_CMD) ||
                        (state_q == S_POLL)  || (state_q == S_TAIL);
  assign req_o      = in_bus_state && !pend_q;
  assign req_we_o   = (state_q == S_CMD) || (state_q == S_TAIL);
  assign req_addr_o = addr_q;
  always_comb begin
    if (state_q == S_TAIL)
      req_wdata_o = (op_q == OP_PROG && idx_q == 3'd0) ? lanes(CMD_CLRST) : lanes(CMD_ARRAY);
    else
      req_wdata_o = head_word(op_q, idx_q, data_q);
  end

  assign busy_o    = state_q != S_IDLE;
  assign done_o    = state_q == S_DONE;
  assign result_o  = res_q;
  assign tmo_clr_o = state_q != S_POLL;
  assign tmo_en_o  = state_q == S_POLL;
  assign set_clr_o = state_q != S_SETTLE;
  assign set_en_o  = state_q == S_SETTLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_ERASE;
      addr_q  <= '0;
      data_q  <= '0;
      elim_q  <= '0;
      plim_q  <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      if (req_o)       pend_q <= 1'b1;
      else if (resp_i) pend_q <= 1'b0;

      unique case (state_q)
        S_IDLE: begin
          if (start_i && op_e'(op_i) != OP_RSVD) begin
            op_q    <= op_e'(op_i);
            addr_q  <= addr_i;
            data_q  <= data_i;
            elim_q  <= erase_tmo_i;
            plim_q  <= prog_tmo_i;
            idx_q   <= '0;
            res_q   <= RES_OK;
            state_q <= (op_e'(op_i) == OP_PROG) ? S_CHECK : S_CMD;
          end
        end
        S_CHECK: begin
          if (resp_i) begin
            if ((rdata_i & data_q) != data_q) begin
              res_q   <= RES_DIRTY;
              state_q <= S_DONE;
            end else begin
              state_q <= S_CMD;
            end
          end
        end
        S_CMD: begin
          if (resp_i) begin
            if (last_head) begin
              idx_q   <= '0;
              state_q <= (op_q == OP_ERASE) ? S_SETTLE : S_POLL;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end
        end
        S_SETTLE: begin
          if (set_cnt_i == SET_LAST) state_q <= S_POLL;
        end
        S_POLL: begin
          if (resp_i) begin
            if (st_ready) begin
              if (op_q == OP_UNLOCK) begin
                state_q <= S_DONE;
              end else begin
                res_q   <= (op_q == OP_PROG && st_wrerr) ? RES_FAIL : RES_OK;
                state_q <= S_TAIL;
              end
            end else if ((op_q == OP_ERASE && st_lock) || tmo_over) begin
              res_q   <= RES_FAIL;
              state_q <= S_TAIL;
            end
          end
        end
        S_TAIL: begin
          if (resp_i) begin
            if (last_tail) state_q <= S_DONE;
            else           idx_q   <= idx_q + 3'd1;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW         = 24,
  parameter int TW         = 24,
  parameter int SETTLE_CYC = 50000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   data_i,
  input  logic [TW-1:0] erase_tmo_i,
  input  logic [TW-1:0] prog_tmo_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [31:0]   bus_rdata_i
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic          req, req_we, resp;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata, rdata;
  logic          tmo_clr, tmo_en, set_clr, set_en;
  logic [TW-1:0] tmo_cnt;
  logic [SW-1:0] set_cnt;

  nor_seq_ctrl #(.AW(AW), .TW(TW), .SETTLE_CYC(SETTLE_CYC), .SW(SW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .addr_i, .data_i, .erase_tmo_i, .prog_tmo_i,
    .busy_o, .done_o, .result_o,
    .req_o(req), .req_we_o(req_we), .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .resp_i(resp), .rdata_i(rdata),
    .tmo_clr_o(tmo_clr), .tmo_en_o(tmo_en), .tmo_cnt_i(tmo_cnt),
    .set_clr_o(set_clr), .set_en_o(set_en), .set_cnt_i(set_cnt)
  );

  nor_bus_port #(.AW(AW)) u_port (
    .clk_i, .rst_ni,
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_o(resp), .rdata_o(rdata),
    .bus_valid_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ready_i, .bus_rdata_i
  );

  nor_cyc_cnt #(.W(TW)) u_tmo_cnt (
    .clk_i, .rst_ni, .clr_i(tmo_clr), .en_i(tmo_en), .cnt_o(tmo_cnt)
  );

  nor_cyc_cnt #(.W(SW)) u_settle_cnt (
    .clk_i, .rst_ni, .clr_i(set_clr), .en_i(set_en), .cnt_o(set_cnt)
  );
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    result_o,
  input logic          bus_valid_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [31:0]   bus_wdata_o,
  input logic          bus_ready_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_valid_o && !done_o)); // R1

  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i != 2'd3) |=> busy_o); // R2

  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd3) |=> !busy_o); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R2

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o); // R3

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      ($stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o))); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i) |=> !bus_valid_o); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12

  AST_RESULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != 2'd3)); // R12
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
  .bus_valid_o(bus_valid_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
  localparam int AW = 16;
  localparam int TW = 16;
  localparam int SC = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   data_i = '0;
  logic [TW-1:0] erase_tmo_i = '0;
  logic [TW-1:0] prog_tmo_i = '0;
  logic          busy_o, done_o, bus_valid_o, bus_we_o;
  logic [1:0]    result_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0]   bus_wdata_o;
  logic          bus_ready_i = 1'b0;
  logic [31:0]   bus_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  nor_cmd_seq #(.AW(AW), .TW(TW), .SETTLE_CYC(SC)) dut_i (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0;
  bit in_op = 0, pre_read = 0, cur_erase = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [1:0]    exp_res = '0;
  string         cur_req = "";
  logic [31:0]   mem_word = '1, st_idle = 32'h0080_0080;
  logic [31:0]   stq[$];
  logic [AW-1:0] ew_addr[$];
  logic [31:0]   ew_data[$];
  int last_conf = 0, first_poll = -1, done_cyc = 0, lat_cnt = 0, lat_sel = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // bus responder and per-clock comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (!in_op && start_i && op_i != 2'd3) in_op = 1;
      chk("R2 busy", {31'd0, busy_o}, {31'd0, in_op});
      bus_ready_i = 1'b0;
      if (bus_valid_o) begin
        if (lat_cnt > 0) lat_cnt--;
        else begin
          bus_ready_i = 1'b1;
          lat_sel = (lat_sel + 1) % 3;
          lat_cnt = lat_sel;
          chk("R3 addr", {16'd0, bus_addr_o}, {16'd0, cur_addr});
          if (bus_we_o) begin
            if (ew_data.size() == 0) begin
              n_cmp++; n_bad++;
              $display("FAIL %s extra write act=%h exp=none", cur_req, bus_wdata_o);
            end else begin
              void'(ew_addr.pop_front());
              chk({cur_req, " write"}, bus_wdata_o, ew_data.pop_front());
            end
            if (bus_wdata_o == 32'hD0D0_D0D0) last_conf = cyc;
          end else if (pre_read) begin
            bus_rdata_i = mem_word;
            pre_read = 0;
          end else begin
            if (first_poll < 0) begin
              first_poll = cyc;
              if (cur_erase) chk("R5 settle", {31'd0, (cyc - last_conf) > SC}, 32'd1);
            end
            bus_rdata_i = (stq.size() != 0) ? stq.pop_front() : st_idle;
          end
        end
      end
      if (done_o) begin
        chk({cur_req, " result"}, {30'd0, result_o}, {30'd0, exp_res});
        chk({cur_req, " writes left"}, ew_data.size(), 32'd0);
        done_cyc = cyc;
        in_op = 0;
        done_cnt++;
      end
    end
  end

  task automatic push_w(input logic [31:0] w);
    ew_addr.push_back(cur_addr);
    ew_data.push_back(w);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [1:0] res, input string req);
    int d0;
    d0 = done_cnt;
    cur_addr = a; exp_res = res; cur_req = req;
    cur_erase = (op == 2'd0); pre_read = (op == 2'd1); first_poll = -1;
    @(negedge clk_i);
    start_i <= 1'b1; op_i <= op; addr_i <= a; data_i <= d;
    @(negedge clk_i);
    start_i <= 1'b0;
    while (done_cnt == d0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog act=hung exp=done");
    summary();
  end

  initial begin
    erase_tmo_i = 16'd1000;
    prog_tmo_i  = 16'd1000;
    repeat (3) @(negedge clk_i);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 valid", {31'd0, bus_valid_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4 R5 R6: erase, half-ready words polled again
    cur_addr = 16'h0400;
    foreach (ew_data[i]) ;
    push_w(32'hFFFF_FFFF); push_w(32'h5050_5050); push_w(32'h2020_2020);
    push_w(32'hD0D0_D0D0); push_w(32'hD0D0_D0D0); push_w(32'hFFFF_FFFF);
    stq = '{32'h0, 32'h0000_0080, 32'h0080_0000};
    st_idle = 32'h0080_0080;
    run_op(2'd0, 16'h0400, 32'h0, 2'd0, "R6 erase ok");
    chk("R6 polls consumed", stq.size(), 32'd0);

    // R7 erase lock error
    cur_addr = 16'h0800;
    push_w(32'hFFFF_FFFF); push_w(32'h5050_5050); push_w(32'h2020_2020);
    push_w(32'hD0D0_D0D0); push_w(32'hD0D0_D0D0); push_w(32'hFFFF_FFFF);
    stq = '{32'h0, 32'h0020_0000};
    run_op(2'd0, 16'h0800, 32'h0, 2'd1, "R7 erase lock");

    // R9 program ok on blank word
    cur_addr = 16'h0013; mem_word = 32'hFFFF_FFFF;
    push_w(32'h1010_1010); push_w(32'h1234_5678);
    push_w(32'h5050_5050); push_w(32'hFFFF_FFFF);
    stq = '{32'h0000_0080};
    run_op(2'd1, 16'h0013, 32'h1234_5678, 2'd0, "R9 program ok");

    // R9 program, partly programmed word still compatible
    cur_addr = 16'h0014; mem_word = 32'hF0F0_F0F0;
    push_w(32'h1010_1010); push_w(32'h1020_3040);
    push_w(32'h5050_5050); push_w(32'hFFFF_FFFF);
    run_op(2'd1, 16'h0014, 32'h1020_3040, 2'd0, "R9 program subset");

    // R9 program write error flag at ready
    cur_addr = 16'h0015; mem_word = 32'hFFFF_FFFF;
    push_w(32'h1010_1010); push_w(32'hA5A5_0000);
    push_w(32'h5050_5050); push_w(32'hFFFF_FFFF);
    stq = '{32'h00C0_0080};
    run_op(2'd1, 16'h0015, 32'hA5A5_0000, 2'd1, "R9 program wrerr");

    // R8 not erased: no write
    cur_addr = 16'h0016; mem_word = 32'h0000_FFFF;
    run_op(2'd1, 16'h0016, 32'h1234_5678, 2'd2, "R8 dirty");

    // R10 unlock, with a stray start while busy (R2)
    cur_addr = 16'h0C00;
    push_w(32'hFFFF_FFFF); push_w(32'h5050_5050);
    push_w(32'h6060_6060); push_w(32'hD0D0_D0D0);
    stq = '{32'h0, 32'h0};
    fork
      run_op(2'd2, 16'h0C00, 32'h0, 2'd0, "R10 unlock");
      begin
        repeat (5) @(negedge clk_i);
        start_i <= 1'b1; op_i <= 2'd0; addr_i <= 16'h7777;
        @(negedge clk_i);
        start_i <= 1'b0;
      end
    join

    // R2 reserved op ignored
    cur_req = "R2 reserved";
    @(negedge clk_i);
    start_i <= 1'b1; op_i <= 2'd3;
    @(negedge clk_i);
    start_i <= 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R2 reserved busy", {31'd0, busy_o}, 32'd0);
    chk("R2 reserved done", done_cnt, 32'd7);

    // R11 timeouts: status never ready
    st_idle = 32'h0;
    erase_tmo_i = 16'd30;
    cur_addr = 16'h1000;
    push_w(32'hFFFF_FFFF); push_w(32'h5050_5050); push_w(32'h2020_2020);
    push_w(32'hD0D0_D0D0); push_w(32'hD0D0_D0D0); push_w(32'hFFFF_FFFF);
    run_op(2'd0, 16'h1000, 32'h0, 2'd1, "R11 erase tmo");
    chk("R11 erase not early", {31'd0, (done_cyc - first_poll) > 30}, 32'd1);

    prog_tmo_i = 16'd25;
    cur_addr = 16'h0020; mem_word = 32'hFFFF_FFFF;
    push_w(32'h1010_1010); push_w(32'h0000_0001);
    push_w(32'h5050_5050); push_w(32'hFFFF_FFFF);
    run_op(2'd1, 16'h0020, 32'h0000_0001, 2'd1, "R11 prog tmo");
    chk("R11 prog not early", {31'd0, (done_cyc - first_poll) > 25}, 32'd1);

    cur_addr = 16'h2000;
    push_w(32'hFFFF_FFFF); push_w(32'h5050_5050);
    push_w(32'h6060_6060); push_w(32'hD0D0_D0D0); push_w(32'hFFFF_FFFF);
    run_op(2'd2, 16'h2000, 32'h0, 2'd1, "R11 unlock tmo");
    chk("R11 unlock not early", {31'd0, (done_cyc - first_poll) > 30}, 32'd1);

    chk("R12 done count", done_cnt, 32'd10);
    summary();
  end
endmodule